// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash model. It watches bus writes (address, data, write strobe), recognises the multi-write unlock sequences that select identification read and automatic chip or sector erase, and reports its operating mode on a two-bit output. Reads return array data, identification codes or erase status, depending on the mode.

The erase itself is a self-timed busy period counted in clock cycles. While it runs, a ready output is low and every read returns a status byte. In that byte one bit flips on each read, so software can poll until the erase finishes. A test input holds back completion so that the time limit can be reached. The block then stays in a failed state, shown by a status bit, until the reset command is written. All bus inputs are sampled on the rising clock edge, and read data is registered. A read and a write must not be issued in the same cycle.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, mode is 0 (array read), ready is 1, rdata is 00h, erase_whole is 0 and erase_sector is 0. The mode codes are 0 = array read, 1 = identification read, 2 = erasing, 3 = erase failed.
- R2: In array-read mode, a read sampled at a clock edge puts array_rdata on rdata after that edge.
- R3: The writes AAh at 555h, 55h at 2AAh and 90h at 555h select mode 1. In mode 1 a read with addr[1:0]=00 returns MFR_CODE (C2h), addr[1:0]=01 returns DEV_CODE (5Bh by default), and any other addr[1:0] returns 00h. Only addr[10:0] is compared for the unlock addresses when FULL_DECODE is 0.
- R4: A write of F0h, at any address, puts the block in mode 0 with ready 1 after that edge, from every state: part-way through a sequence, in identification mode, while erasing, and after a failure. In mode 1, all other writes are ignored.
- R5: Any write that does not match the next expected step of a sequence returns the decoder to mode 0. The writes that follow must then start again from the first unlock write.
- R6: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h start a chip erase on the edge of the last write: mode 2, ready 0 and erase_whole 1.
- R7: The same sequence ending in 30h at any address starts a sector erase. erase_sector takes addr[ADDR_W-1:SECT_LSB] of that last write, and erase_whole is 0.
- R8: In mode 2, each read returns a status byte with bit 7 = 0, bit 5 = 0 and bits 4..0 = 0. Bit 6 is 0 on the first read after the start and inverts on every later read.
- R9: Without force_timeout, mode 2 lasts exactly ERASE_CYCLES cycles, then mode 0 with ready 1. Writes other than F0h have no effect during that time.
- R10: If force_timeout is high while erasing, the block enters mode 3 after TIMEOUT_CYCLES cycles in mode 2. In mode 3, ready stays 0 and status reads have bit 5 = 1, bit 7 = 0, and bit 6 continues to toggle. Only F0h leaves mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Bus write data (command byte) |
| array_rdata | input | 8 | Data from the memory array for the current address |
| force_timeout | input | 1 | Test input: blocks erase completion so the time limit is reached |
| rdata | output | 8 | Registered read data |
| mode | output | 2 | 0 array read, 1 identification, 2 erasing, 3 erase failed |
| ready | output | 1 | Low while erasing or failed |
| erase_whole | output | 1 | Last erase started was a chip erase |
| erase_sector | output | ADDR_W-SECT_LSB | Sector index of the last sector erase |

## Verification
A wrong sequence state stays hidden until the step that completes a command: the mode output then fails to change, or changes one write too early. So each broken-sequence case is followed by a full command to expose any hidden partial progress. A wrong erase counter shows as ready returning a cycle early or late. A wrong toggle register shows as two status reads in a row giving the same bit 6. Each of these shows at the ports within one or two cycles of the event that should expose it.

// File: rtl/nfcd_pkg.sv
package nfcd_pkg;
   typedef enum logic [3:0] {
      ST_ARRAY, ST_UNL1, ST_UNL2, ST_IDENT,
      ST_SETUP, ST_UNL4, ST_UNL5, ST_ERASE, ST_FAIL
   } cst_t;

   localparam logic [1:0] MD_ARRAY = 2'd0;
   localparam logic [1:0] MD_IDENT = 2'd1;
   localparam logic [1:0] MD_ERASE = 2'd2;
   localparam logic [1:0] MD_FAIL  = 2'd3;

   localparam logic [7:0] OP_RESET  = 8'hF0;
   localparam logic [7:0] OP_KEY1   = 8'hAA;
   localparam logic [7:0] OP_KEY2   = 8'h55;
   localparam logic [7:0] OP_IDENT  = 8'h90;
   localparam logic [7:0] OP_SETUP  = 8'h80;
   localparam logic [7:0] OP_CHIP   = 8'h10;
   localparam logic [7:0] OP_SECTOR = 8'h30;

   localparam logic [10:0] ADR_KEY1 = 11'h555;
   localparam logic [10:0] ADR_KEY2 = 11'h2AA;
endpackage

// File: rtl/nfcd_seq.sv
module nfcd_seq
   import nfcd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   input  logic       hit_key1,
   input  logic       hit_key2,
   input  logic       tmr_done,
   input  logic       tmr_expire,
   output cst_t       state,
   output logic       start_pulse,
   output logic       start_chip
);
   cst_t nxt;
   logic k1_ok, k2_ok;

   assign k1_ok = wr_en && hit_key1 && (wdata == OP_KEY1);
   assign k2_ok = wr_en && hit_key2 && (wdata == OP_KEY2);

   always_comb begin
      nxt         = state;
      start_pulse = 1'b0;
      start_chip  = 1'b0;
      if (wr_en && wdata == OP_RESET) begin
         nxt = ST_ARRAY;
      end else begin
         case (state)
            ST_ARRAY: if (wr_en) nxt = k1_ok ? ST_UNL1 : ST_ARRAY;
            ST_UNL1:  if (wr_en) nxt = k2_ok ? ST_UNL2 : ST_ARRAY;
            ST_UNL2: begin
               if (wr_en) begin
                  if (hit_key1 && wdata == OP_IDENT)      nxt = ST_IDENT;
                  else if (hit_key1 && wdata == OP_SETUP) nxt = ST_SETUP;
                  else                                     nxt = ST_ARRAY;
               end
            end
            ST_IDENT: nxt = ST_IDENT;
            ST_SETUP: if (wr_en) nxt = k1_ok ? ST_UNL4 : ST_ARRAY;
            ST_UNL4:  if (wr_en) nxt = k2_ok ? ST_UNL5 : ST_ARRAY;
            ST_UNL5: begin
               if (wr_en) begin
                  if (hit_key1 && wdata == OP_CHIP) begin
                     nxt         = ST_ERASE;
                     start_pulse = 1'b1;
                     start_chip  = 1'b1;
                  end else if (wdata == OP_SECTOR) begin
                     nxt         = ST_ERASE;
                     start_pulse = 1'b1;
                  end else begin
                     nxt = ST_ARRAY;
                  end
               end
            end
            ST_ERASE: begin
               if (tmr_done)        nxt = ST_ARRAY;
               else if (tmr_expire) nxt = ST_FAIL;
            end
            ST_FAIL:  nxt = ST_FAIL;
            default:  nxt = ST_ARRAY;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_ARRAY;
      else        state <= nxt;
   end
endmodule

// File: rtl/nfcd_timer.sv
module nfcd_timer #(
   parameter int unsigned ERASE_CYCLES   = 24,
   parameter int unsigned TIMEOUT_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   input  logic hold_off,
   output logic done,
   output logic expire
);
   localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (start) cnt <= '0;
      else if (run)   cnt <= cnt + 1'b1;
   end

   assign done   = run && !hold_off && (cnt == CW'(ERASE_CYCLES - 1));
   assign expire = run && (cnt == CW'(TIMEOUT_CYCLES - 1));
endmodule

// File: rtl/nfcd_rdpath.sv
module nfcd_rdpath
   import nfcd_pkg::*;
#(
   parameter logic [7:0] MFR_CODE = 8'hC2,
   parameter logic [7:0] DEV_CODE = 8'h5B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_en,
   input  cst_t       state,
   input  logic [1:0] sel,
   input  logic [7:0] array_rdata,
   input  logic       start,
   output logic [7:0] rdata
);
   logic tog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= 8'h00;
         tog   <= 1'b0;
      end else begin
         if (rd_en) begin
            case (state)
               ST_IDENT: begin
                  case (sel)
                     2'b00:   rdata <= MFR_CODE;
                     2'b01:   rdata <= DEV_CODE;
                     default: rdata <= 8'h00;
                  endcase
               end
               ST_ERASE: begin
                  rdata <= {1'b0, tog, 1'b0, 5'b00000};
                  tog   <= ~tog;
               end
               ST_FAIL: begin
                  rdata <= {1'b0, tog, 1'b1, 5'b00000};
                  tog   <= ~tog;
               end
               default: rdata <= array_rdata;
            endcase
         end
         if (start) tog <= 1'b0;
      end
   end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
   import nfcd_pkg::*;
#(
   parameter int unsigned ADDR_W         = 12,
   parameter int unsigned SECT_LSB       = 8,
   parameter int unsigned ERASE_CYCLES   = 24,
   parameter int unsigned TIMEOUT_CYCLES = 40,
   parameter logic [7:0]  MFR_CODE       = 8'hC2,
   parameter logic [7:0]  DEV_CODE       = 8'h5B,
   parameter bit          FULL_DECODE    = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       rd_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [7:0]                 wdata,
   input  logic [7:0]                 array_rdata,
   input  logic                       force_timeout,
   output logic [7:0]                 rdata,
   output logic [1:0]                 mode,
   output logic                       ready,
   output logic                       erase_whole,
   output logic [ADDR_W-SECT_LSB-1:0] erase_sector
);
   localparam int unsigned SECT_W = ADDR_W - SECT_LSB;

   generate
      if (ADDR_W < 11)                      $error("ADDR_W must cover the unlock addresses");
      if (SECT_LSB >= ADDR_W)               $error("SECT_LSB must lie below ADDR_W");
      if (ERASE_CYCLES < 2)                 $error("ERASE_CYCLES too small");
      if (TIMEOUT_CYCLES <= ERASE_CYCLES)   $error("TIMEOUT_CYCLES must exceed ERASE_CYCLES");
   endgenerate

   logic hit_key1, hit_key2;

   generate
      if (FULL_DECODE) begin : g_full
         assign hit_key1 = (addr == ADDR_W'(ADR_KEY1));
         assign hit_key2 = (addr == ADDR_W'(ADR_KEY2));
      end else begin : g_low
         assign hit_key1 = (addr[10:0] == ADR_KEY1);
         assign hit_key2 = (addr[10:0] == ADR_KEY2);
      end
   endgenerate

   cst_t state;
   logic start_pulse, start_chip, tmr_done, tmr_expire;

   nfcd_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wdata       (wdata),
      .hit_key1    (hit_key1),
      .hit_key2    (hit_key2),
      .tmr_done    (tmr_done),
      .tmr_expire  (tmr_expire),
      .state       (state),
      .start_pulse (start_pulse),
      .start_chip  (start_chip)
   );

   nfcd_timer #(
      .ERASE_CYCLES   (ERASE_CYCLES),
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_pulse),
      .run      (state == ST_ERASE),
      .hold_off (force_timeout),
      .done     (tmr_done),
      .expire   (tmr_expire)
   );

   nfcd_rdpath #(
      .MFR_CODE (MFR_CODE),
      .DEV_CODE (DEV_CODE)
   ) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_en       (rd_en),
      .state       (state),
      .sel         (addr[1:0]),
      .array_rdata (array_rdata),
      .start       (start_pulse),
      .rdata       (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         erase_whole  <= 1'b0;
         erase_sector <= '0;
      end else if (start_pulse) begin
         erase_whole  <= start_chip;
         erase_sector <= start_chip ? '0 : addr[ADDR_W-1:SECT_LSB];
      end
   end

   always_comb begin
      case (state)
         ST_IDENT: mode = MD_IDENT;
         ST_ERASE: mode = MD_ERASE;
         ST_FAIL:  mode = MD_FAIL;
         default:  mode = MD_ARRAY;
      endcase
   end

   assign ready = (state != ST_ERASE) && (state != ST_FAIL);

   logic [SECT_W-1:0] unused_sect_w;
   assign unused_sect_w = '0;
endmodule

// File: rtl/nfcd_checker.sv
module nfcd_checker #(
   parameter int unsigned ADDR_W         = 12,
   parameter int unsigned TIMEOUT_CYCLES = 40,
   parameter logic [7:0]  MFR_CODE       = 8'hC2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic              force_timeout,
   input logic [7:0]        rdata,
   input logic [1:0]        mode,
   input logic              ready
);
   logic [31:0] busy_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            busy_n <= '0;
      else if (mode == 2'd2) busy_n <= busy_n + 1;
      else                   busy_n <= '0;
   end

   // R4: reset command always lands in array-read mode
   a_r4_reset_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata == 8'hF0) |=> (mode == 2'd0 && ready));

   // R3: manufacturer code on identification read at offset 0
   a_r3_mfr_code: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && mode == 2'd1 && addr[1:0] == 2'b00) |=> (rdata == MFR_CODE));

   // R8: status bit 7 is low while erasing
   a_r8_q7_low: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && mode == 2'd2) |=> (rdata[7] == 1'b0));

   // R6: erase only begins on a final erase command write
   a_r6_erase_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && $past(mode) != 2'd2) |->
         ($past(wr_en) && ($past(wdata) == 8'h10 || $past(wdata) == 8'h30)));

   // R6: ready only falls because of a write
   a_r6_ready_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(wr_en));

   // R10: failure is sticky until the reset command
   a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && !(wr_en && wdata == 8'hF0)) |=> (mode == 2'd3 && !ready));

   // R10: forced erase never completes normally
   a_r10_forced_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && force_timeout && !(wr_en && wdata == 8'hF0)) |=> (mode == 2'd2 || mode == 2'd3));

   // R9: erasing never outlasts the time limit
   a_r9_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_n <= TIMEOUT_CYCLES);
endmodule

bind nor_cmd_decoder nfcd_checker #(
   .ADDR_W         (ADDR_W),
   .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
   .MFR_CODE       (MFR_CODE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .rd_en         (rd_en),
   .addr          (addr),
   .wdata         (wdata),
   .force_timeout (force_timeout),
   .rdata         (rdata),
   .mode          (mode),
   .ready         (ready)
);

// File: tb/tb_nor_cmd_decoder.sv
module tb_nor_cmd_decoder;
   localparam int ERASE_N = 24;
   localparam int LIMIT_N = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  array_rdata = '0;
   logic        force_timeout = 1'b0;
   logic [7:0]  rdata;
   logic [1:0]  mode;
   logic        ready;
   logic        erase_whole;
   logic [3:0]  erase_sector;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   nor_cmd_decoder #(
      .ADDR_W(12), .SECT_LSB(8), .ERASE_CYCLES(ERASE_N), .TIMEOUT_CYCLES(LIMIT_N),
      .MFR_CODE(8'hC2), .DEV_CODE(8'h5B), .FULL_DECODE(1'b0)
   ) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .array_rdata(array_rdata), .force_timeout(force_timeout),
      .rdata(rdata), .mode(mode), .ready(ready), .erase_whole(erase_whole),
      .erase_sector(erase_sector)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // every task starts and ends at a falling edge and spans one cycle
   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [7:0] arr, output logic [7:0] q);
      rd_en = 1'b1; addr = a; array_rdata = arr;
      @(negedge clk);
      rd_en = 1'b0;
      q = rdata;
   endtask

   task automatic erase_cmd(input logic [11:0] a, input logic [7:0] d);
      wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
      wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(a, d);
   endtask

   // reference model of the sequence state: 0 array,1..2 unlock,3 ident,4 setup,5..6 unlock
   function automatic int mnext(int st, logic [11:0] a, logic [7:0] d);
      logic k1, k2;
      k1 = (a[10:0] == 11'h555);
      k2 = (a[10:0] == 11'h2AA);
      if (d == 8'hF0) return 0;
      case (st)
         0: return (k1 && d == 8'hAA) ? 1 : 0;
         1: return (k2 && d == 8'h55) ? 2 : 0;
         2: return (k1 && d == 8'h90) ? 3 : ((k1 && d == 8'h80) ? 4 : 0);
         3: return 3;
         4: return (k1 && d == 8'hAA) ? 5 : 0;
         5: return (k2 && d == 8'h55) ? 6 : 0;
         default: return 0;
      endcase
   endfunction

   function automatic logic [7:0] mread(int st, logic [11:0] a, logic [7:0] arr);
      if (st != 3) return arr;
      case (a[1:0])
         2'b00:   return 8'hC2;
         2'b01:   return 8'h5B;
         default: return 8'h00;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] q, q2;
      int t;
      int st;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 mode", 32'(mode), 0); chk("R1 ready", 32'(ready), 1);
      chk("R1 rdata", 32'(rdata), 0); chk("R1 erase_whole", 32'(erase_whole), 0);
      chk("R1 erase_sector", 32'(erase_sector), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 array read
      rd(12'h004, 8'h3C, q); chk("R2 array read", 32'(q), 32'h3C);
      // R3 identification
      wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
      chk("R3 ident mode", 32'(mode), 1);
      rd(12'h000, 8'h77, q); chk("R3 mfr code", 32'(q), 32'hC2);
      rd(12'h001, 8'h77, q); chk("R3 dev code", 32'(q), 32'h5B);
      rd(12'h002, 8'h77, q); chk("R3 other offset", 32'(q), 0);
      rd(12'hFF3, 8'h77, q); chk("R3 offset 3", 32'(q), 0);
      // R4 writes ignored in ident, then F0 leaves
      wr(12'h555, 8'hAA); chk("R4 ident ignores write", 32'(mode), 1);
      rd(12'h001, 8'h77, q); chk("R4 still ident", 32'(q), 32'h5B);
      wr(12'h123, 8'hF0); chk("R4 F0 leaves ident", 32'(mode), 0);
      rd(12'h001, 8'h66, q); chk("R4 array after F0", 32'(q), 32'h66);
      // R5 broken sequences
      wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h123, 8'h90);
      chk("R5 wrong address", 32'(mode), 0);
      wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
      chk("R5 no leftover progress", 32'(mode), 0);
      wr(12'h555, 8'hAA); wr(12'h2AA, 8'h54); wr(12'h555, 8'h90);
      chk("R5 wrong data", 32'(mode), 0);
      // R4 F0 mid sequence
      wr(12'h555, 8'hAA); wr(12'h000, 8'hF0); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
      chk("R4 F0 mid sequence", 32'(mode), 0);
      // R6 chip erase, R8 status, R9 duration
      erase_cmd(12'h555, 8'h10);
      t = 0;
      chk("R6 erase mode", 32'(mode), 2); chk("R6 ready low", 32'(ready), 0);
      chk("R6 erase_whole", 32'(erase_whole), 1);
      rd(12'h000, 8'hFF, q); t++; chk("R8 first status", 32'(q), 32'h00);
      rd(12'h000, 8'hFF, q); t++; chk("R8 second status", 32'(q), 32'h40);
      rd(12'h000, 8'hFF, q); t++; chk("R8 third status", 32'(q), 32'h00);
      wr(12'h555, 8'hAA); t++; chk("R9 write ignored while erasing", 32'(mode), 2);
      while (!ready && t < 1000) begin @(negedge clk); t++; end
      chk("R9 erase length", 32'(t), 32'(ERASE_N));
      chk("R9 back to array", 32'(mode), 0);
      rd(12'h010, 8'hFF, q); chk("R9 array after erase", 32'(q), 32'hFF);
      wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
      chk("R9 ignored write left no progress", 32'(mode), 0);
      // R7 sector erase then R4 abort
      erase_cmd(12'hA7C, 8'h30);
      chk("R7 erase mode", 32'(mode), 2); chk("R7 erase_whole", 32'(erase_whole), 0);
      chk("R7 sector index", 32'(erase_sector), 32'hA);
      wr(12'h000, 8'hF0);
      chk("R4 abort erase mode", 32'(mode), 0); chk("R4 abort ready", 32'(ready), 1);
      // R10 forced timeout
      force_timeout = 1'b1;
      erase_cmd(12'h555, 8'h10);
      t = 0;
      while (mode == 2'd2 && t < 1000) begin @(negedge clk); t++; end
      chk("R10 time limit", 32'(t), 32'(LIMIT_N));
      chk("R10 fail mode", 32'(mode), 3); chk("R10 ready low", 32'(ready), 0);
      rd(12'h000, 8'hFF, q); chk("R10 fail status", 32'(q), 32'h20);
      rd(12'h000, 8'hFF, q2); chk("R10 fail status toggles", 32'(q2), 32'h60);
      force_timeout = 1'b0;
      wr(12'h555, 8'hAA); repeat (5) @(negedge clk);
      chk("R10 fail held", 32'(mode), 3);
      wr(12'h000, 8'hF0);
      chk("R10 F0 clears fail", 32'(mode), 0); chk("R10 ready back", 32'(ready), 1);
      // random mix against the sequence model (R2 R3 R4 R5)
      st = 0;
      for (int i = 0; i < 400; i++) begin
         logic [11:0] a;
         logic [7:0]  d;
         int sel;
         if ($urandom % 3 == 0) begin
            a = 12'($urandom); d = 8'($urandom);
            rd(a, d, q);
            chk("R3 random read", 32'(q), 32'(mread(st, a, d)));
         end else begin
            sel = int'($urandom % 8);
            a = 12'($urandom); d = 8'($urandom);
            case (sel)
               0, 1: begin a = {a[11], 11'h555}; d = 8'hAA; end
               2:    begin a = {a[11], 11'h2AA}; d = 8'h55; end
               3:    begin a = {a[11], 11'h555}; d = 8'h90; end
               4:    begin a = {a[11], 11'h555}; d = 8'h80; end
               5:    d = 8'hF0;
               default: if (d == 8'h10 || d == 8'h30) d = 8'h11;
            endcase
            wr(a, d);
            st = mnext(st, a, d);
            chk("R5 random mode", 32'(mode), (st == 3) ? 1 : 0);
         end
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule